// File: doc/BRIEF.md
# Frequency-Filtered Trace Promotion Cache

This block holds instruction traces for a fetch front end in two levels. A large, direct-mapped main store answers after a fixed multi-cycle latency. A small, direct-mapped fast store answers in one cycle. The fast store is not filled on every access. Each main-store line keeps a small saturating use count, and a line is copied into the fast store only after it has been read often enough. This keeps rarely used traces from evicting hot ones.

A lookup first probes the fast store. On a fast hit the result comes back on the next cycle and the main store is not touched. On a fast miss the block reads the main store. The response strobe then rises `MAIN_LAT` cycles after the request. If that read hits the main store and the line's count meets the threshold, the line is copied into the fast store. A separate write port installs lines in the main store. Main-store writes never touch the fast store, so an old copy there stays valid.

Only one lookup is in flight at a time, and `lk_ready` shows when a new request is accepted. The asynchronous reset is released through a two-stage synchronizer.

Top module: `trace_promo_cache`

## Requirements
- R1: A lookup accepted while `lk_ready` is high that hits the fast store raises `lk_valid` on the next cycle, with `lk_hit`=1, `lk_fast`=1 and the stored payload.
- R2: A lookup that misses the fast store raises `lk_valid` exactly `MAIN_LAT` cycles after the request cycle, with `lk_fast`=0. `lk_ready` is low in between, and requests made during that time are ignored.
- R3: A lookup that misses both stores returns `lk_hit`=0 and `lk_data`=0. The main store is direct-mapped: index = `addr[MAIN_IDX_W-1:0]`, tag = the remaining upper bits.
- R4: A main-store write installs the line and clears that line's use count to zero.
- R5: Each main-store read hit counts as the k-th hit on that line since the line was last written. That hit copies the line into the fast store when k-1 is at least `promo_thr`. Its count then increments.
- R6: With `promo_thr`=0, every main-store read hit copies the line into the fast store.
- R7: The use count saturates at 2^`CNT_W`-1 and never wraps. With `promo_thr` at that maximum, a line read more often than that is still promoted.
- R8: Promotion does not clear the count. A line evicted from the fast store is promoted again on its next main-store hit.
- R9: A main-store write does not update or invalidate a copy already in the fast store. Later fast hits return the old payload.
- R10: A write to the main-store set being read on the finishing cycle of a main read wins. The read returns the old payload, the promotion is dropped, and the count is cleared.
- R11: After reset, every lookup misses, and `lk_ready` is high while `lk_valid` is low.
- R12: The fast store is direct-mapped on `addr[AUX_IDX_W-1:0]`. A promotion overwrites whatever line holds that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup address |
| lk_ready | output | 1 | Block can accept a lookup |
| lk_valid | output | 1 | One-cycle response strobe |
| lk_hit | output | 1 | Response hit in either store |
| lk_fast | output | 1 | Response came from the fast store |
| lk_data | output | DATA_W | Trace payload (zero on miss) |
| wr_en | input | 1 | Main-store write enable |
| wr_addr | input | ADDR_W | Main-store write address |
| wr_data | input | DATA_W | Main-store write payload |
| promo_thr | input | CNT_W | Promotion threshold |

## Verification
Most internal faults show up as a wrong latency at the ports. A use count that wraps, fails to clear, or is reset on promotion moves the first fast hit by at least one lookup. A dropped or extra promotion turns a three-cycle response into a one-cycle one, or the reverse, on the very next lookup of that line. A wrong fast-store update shows up as stale or fresh payload on the next fast hit. The bench sweeps every threshold value and counts the lookups until the first fast hit.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic {
    S_IDLE = 1'b0,
    S_WAIT = 1'b1
  } tpc_state_e;
endpackage

// File: rtl/tpc_aux_store.sv
module tpc_aux_store #(
  parameter int ADDR_W    = 8,
  parameter int AUX_IDX_W = 2,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int SETS  = 1 << AUX_IDX_W;
  localparam int TAG_W = ADDR_W - AUX_IDX_W;

  logic [SETS-1:0]             vld_q;
  logic [SETS-1:0]             vld_d;
  logic [SETS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][DATA_W-1:0] dat_q;

  logic [AUX_IDX_W-1:0] rd_idx, fill_idx;
  logic [TAG_W-1:0]     rd_tag, fill_tag;

  assign rd_idx   = rd_addr[AUX_IDX_W-1:0];
  assign rd_tag   = rd_addr[ADDR_W-1:AUX_IDX_W];
  assign fill_idx = fill_addr[AUX_IDX_W-1:0];
  assign fill_tag = fill_addr[ADDR_W-1:AUX_IDX_W];

  assign rd_hit  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_data = dat_q[rd_idx];

  always_comb begin
    vld_d = vld_q;
    if (fill_en) vld_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_tag;
      dat_q[fill_idx] <= fill_data;
    end
  end

  // R12: a promotion leaves the target set holding the promoted tag
  a_r12_fill_installs: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (vld_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag)));
endmodule

// File: rtl/tpc_main_store.sv
module tpc_main_store #(
  parameter int ADDR_W     = 8,
  parameter int MAIN_IDX_W = 4,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  thr,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  output logic              promote,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << MAIN_IDX_W;
  localparam int TAG_W = ADDR_W - MAIN_IDX_W;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [LINES-1:0]             vld_q, vld_d;
  logic [LINES-1:0][TAG_W-1:0]  tag_q;
  logic [LINES-1:0][DATA_W-1:0] dat_q;
  logic [LINES-1:0][CNT_W-1:0]  cnt_q, cnt_d;

  logic [MAIN_IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0]      rd_tag, wr_tag;
  logic                  line_hit, collide;

  assign rd_idx = rd_addr[MAIN_IDX_W-1:0];
  assign rd_tag = rd_addr[ADDR_W-1:MAIN_IDX_W];
  assign wr_idx = wr_addr[MAIN_IDX_W-1:0];
  assign wr_tag = wr_addr[ADDR_W-1:MAIN_IDX_W];

  assign line_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign collide  = wr_en && (wr_idx == rd_idx);
  assign rd_hit   = line_hit;
  assign rd_data  = dat_q[rd_idx];
  assign promote  = rd_en && line_hit && !collide && (cnt_q[rd_idx] >= thr);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic wr_here, rd_here;
    assign wr_here = wr_en && (wr_idx == MAIN_IDX_W'(g));
    assign rd_here = rd_en && line_hit && (rd_idx == MAIN_IDX_W'(g));
    assign cnt_d[g] = wr_here ? '0 :
                      (rd_here && cnt_q[g] != CNT_TOP) ? cnt_q[g] + 1'b1 :
                      cnt_q[g];

    // R4: a write to this line leaves its count at zero
    a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_here |=> (cnt_q[g] == '0));
    // R7: a saturated count stays saturated unless the line is written
    a_r7_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] == CNT_TOP && !wr_here) |=> (cnt_q[g] == CNT_TOP));
  end

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  // R10: a colliding write leaves the read line's count at zero
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && wr_idx == rd_idx) |=> (cnt_q[$past(rd_idx)] == '0));
endmodule

// File: rtl/tpc_ctrl.sv
module tpc_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int MAIN_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              aux_hit,
  input  logic [DATA_W-1:0] aux_data,
  input  logic              main_hit,
  input  logic [DATA_W-1:0] main_data,
  output logic              ready,
  output logic              main_rd_en,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fast,
  output logic [DATA_W-1:0] rsp_data
);
  import tpc_pkg::*;

  localparam int WAIT_W = (MAIN_LAT > 2) ? $clog2(MAIN_LAT - 1) : 1;
  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(MAIN_LAT - 2);

  tpc_state_e        state_q, state_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [ADDR_W-1:0] addr_q;
  logic              accept, addr_en;
  logic              vld_q, vld_d, hit_q, hit_d, fast_q, fast_d;
  logic [DATA_W-1:0] dat_q, dat_d;

  assign ready      = (state_q == S_IDLE);
  assign accept     = req && ready;
  assign addr_en    = accept;
  assign main_rd_en = (state_q == S_WAIT) && (wait_q == '0);

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    vld_d   = 1'b0;
    hit_d   = hit_q;
    fast_d  = fast_q;
    dat_d   = dat_q;
    if (accept) begin
      if (aux_hit) begin
        vld_d  = 1'b1;
        hit_d  = 1'b1;
        fast_d = 1'b1;
        dat_d  = aux_data;
      end else begin
        state_d = S_WAIT;
        wait_d  = WAIT_INIT;
      end
    end else if (state_q == S_WAIT) begin
      if (wait_q == '0) begin
        state_d = S_IDLE;
        vld_d   = 1'b1;
        hit_d   = main_hit;
        fast_d  = 1'b0;
        dat_d   = main_hit ? main_data : '0;
      end else begin
        wait_d = wait_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      wait_q  <= '0;
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      fast_q  <= 1'b0;
      dat_q   <= '0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      vld_q   <= vld_d;
      hit_q   <= hit_d;
      fast_q  <= fast_d;
      dat_q   <= dat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= req_addr;
  end

  assign cur_addr  = addr_q;
  assign rsp_valid = vld_q;
  assign rsp_hit   = hit_q;
  assign rsp_fast  = fast_q;
  assign rsp_data  = dat_q;

  // R1: a fast-store hit answers on the next cycle
  a_r1_fast_next: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && aux_hit) |=> (rsp_valid && rsp_fast && rsp_hit));
  // R2: a fast-store miss never answers on the next cycle
  a_r2_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !aux_hit) |=> (!rsp_valid && !ready));
  // R3: a miss carries no payload
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0));
endmodule

// File: rtl/trace_promo_cache.sv
module trace_promo_cache #(
  parameter int ADDR_W     = 8,
  parameter int MAIN_IDX_W = 4,
  parameter int AUX_IDX_W  = 2,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 3,
  parameter int MAIN_LAT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ready,
  output logic              lk_valid,
  output logic              lk_hit,
  output logic              lk_fast,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  promo_thr
);
  logic [1:0]        rsync_q;
  logic              srst_n;
  logic              aux_hit, main_hit, main_rd_en, promote;
  logic [DATA_W-1:0] aux_data, main_data;
  logic [ADDR_W-1:0] cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  tpc_aux_store #(
    .ADDR_W(ADDR_W), .AUX_IDX_W(AUX_IDX_W), .DATA_W(DATA_W)
  ) u_aux (
    .clk(clk), .rst_n(srst_n),
    .rd_addr(lk_addr), .rd_hit(aux_hit), .rd_data(aux_data),
    .fill_en(promote), .fill_addr(cur_addr), .fill_data(main_data)
  );

  tpc_main_store #(
    .ADDR_W(ADDR_W), .MAIN_IDX_W(MAIN_IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_main (
    .clk(clk), .rst_n(srst_n),
    .rd_en(main_rd_en), .rd_addr(cur_addr), .thr(promo_thr),
    .rd_hit(main_hit), .rd_data(main_data), .promote(promote),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  tpc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAIN_LAT(MAIN_LAT)
  ) u_ctrl (
    .clk(clk), .rst_n(srst_n),
    .req(lk_req), .req_addr(lk_addr),
    .aux_hit(aux_hit), .aux_data(aux_data),
    .main_hit(main_hit), .main_data(main_data),
    .ready(lk_ready), .main_rd_en(main_rd_en), .cur_addr(cur_addr),
    .rsp_valid(lk_valid), .rsp_hit(lk_hit), .rsp_fast(lk_fast), .rsp_data(lk_data)
  );

  // R6/R5: a promotion only happens on a finishing main read that hit
  a_r5_promote_on_hit: assert property (@(posedge clk) disable iff (!srst_n)
    promote |=> (lk_valid && lk_hit && !lk_fast));
endmodule

// File: tb/sim_trace_promo_cache.sv
module sim_trace_promo_cache;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 3;
  localparam int LAT    = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lk_req;
  logic [ADDR_W-1:0] lk_addr;
  logic              lk_ready, lk_valid, lk_hit, lk_fast;
  logic [DATA_W-1:0] lk_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  promo_thr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  trace_promo_cache #(.ADDR_W(ADDR_W), .MAIN_IDX_W(4), .AUX_IDX_W(2),
    .DATA_W(DATA_W), .CNT_W(CNT_W), .MAIN_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_ready(lk_ready), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_fast(lk_fast),
    .lk_data(lk_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .promo_thr(promo_thr));

  function automatic logic [DATA_W-1:0] pay(input logic [7:0] a, input int gen);
    return {a, 8'(gen * 37 + 5)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_line(input logic [7:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // packed result: {hit, fast, lat[5:0], data}
  task automatic expect_lookup(input logic [7:0] a, input bit eh, input bit ef,
                               input logic [DATA_W-1:0] ed, input string req);
    int lat;
    logic [23:0] act, exp;
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    lat = 1;
    while (!lk_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    act = {lk_hit, lk_fast, 6'(lat), lk_data};
    exp = {eh, ef, 6'(ef ? 1 : LAT), ed};
    check(act == exp, req, 32'(act), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_req = 1'b0; lk_addr = '0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; promo_thr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: idle after reset
    check(lk_ready && !lk_valid, "R11 idle", {30'd0, lk_ready, lk_valid}, 32'h2);

    // R11/R3: every address misses after reset
    for (int a = 0; a < 256; a++)
      expect_lookup(8'(a), 1'b0, 1'b0, '0, "R11 R3 reset miss");

    // R5/R6: threshold sweep, first fast hit at lookup thr+2
    for (int t = 0; t < 8; t++) begin
      logic [7:0] a;
      a = 8'((t << 4) | 5);
      write_line(a, pay(a, t));
      promo_thr = CNT_W'(t);
      for (int k = 1; k <= t + 2; k++)
        expect_lookup(a, 1'b1, k == t + 2, pay(a, t),
                      t == 0 ? "R6 thr0 promote" : "R5 thr sweep");
    end

    // R9: main write does not refresh the fast copy of 0x75
    write_line(8'h75, pay(8'h75, 99));
    expect_lookup(8'h75, 1'b1, 1'b1, pay(8'h75, 7), "R9 stale fast copy");

    // R8/R12: eviction and re-promotion without count reset
    promo_thr = 3'd2;
    write_line(8'h21, pay(8'h21, 1));
    write_line(8'h25, pay(8'h25, 1));
    for (int k = 1; k <= 3; k++)
      expect_lookup(8'h21, 1'b1, 1'b0, pay(8'h21, 1), "R5 warmup");
    expect_lookup(8'h21, 1'b1, 1'b1, pay(8'h21, 1), "R5 promoted");
    promo_thr = 3'd0;
    expect_lookup(8'h25, 1'b1, 1'b0, pay(8'h25, 1), "R12 other line");
    expect_lookup(8'h25, 1'b1, 1'b1, pay(8'h25, 1), "R12 other promoted");
    promo_thr = 3'd2;
    expect_lookup(8'h21, 1'b1, 1'b0, pay(8'h21, 1), "R12 evicted");
    expect_lookup(8'h21, 1'b1, 1'b1, pay(8'h21, 1), "R8 count kept");

    // R7: saturation at 7 with threshold 7
    write_line(8'h42, pay(8'h42, 2));
    write_line(8'h06, pay(8'h06, 2));
    promo_thr = 3'd7;
    for (int k = 1; k <= 8; k++)
      expect_lookup(8'h42, 1'b1, 1'b0, pay(8'h42, 2), "R7 climb");
    expect_lookup(8'h42, 1'b1, 1'b1, pay(8'h42, 2), "R7 promoted at max");
    promo_thr = 3'd0;
    expect_lookup(8'h06, 1'b1, 1'b0, pay(8'h06, 2), "R7 evict");
    promo_thr = 3'd7;
    expect_lookup(8'h42, 1'b1, 1'b0, pay(8'h42, 2), "R7 saturated repromote");
    expect_lookup(8'h42, 1'b1, 1'b1, pay(8'h42, 2), "R7 no wrap");

    // R4: write clears the count
    promo_thr = 3'd1;
    write_line(8'h83, pay(8'h83, 1));
    expect_lookup(8'h83, 1'b1, 1'b0, pay(8'h83, 1), "R4 first hit");
    write_line(8'h83, pay(8'h83, 2));
    expect_lookup(8'h83, 1'b1, 1'b0, pay(8'h83, 2), "R4 count cleared");
    expect_lookup(8'h83, 1'b1, 1'b0, pay(8'h83, 2), "R4 second after clear");
    expect_lookup(8'h83, 1'b1, 1'b1, pay(8'h83, 2), "R4 promoted");

    // R10: write on the finishing cycle of a main read
    promo_thr = 3'd0;
    write_line(8'h97, pay(8'h97, 1));
    @(negedge clk);
    lk_req = 1'b1; lk_addr = 8'h97;
    @(negedge clk);
    lk_req = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h97; wr_data = pay(8'h97, 2);
    @(negedge clk);
    wr_en = 1'b0;
    check(lk_valid && lk_hit && !lk_fast && lk_data == pay(8'h97, 1), "R10 old data",
          {13'd0, lk_valid, lk_hit, lk_fast, lk_data}, {16'h6, pay(8'h97, 1)});
    expect_lookup(8'h97, 1'b1, 1'b0, pay(8'h97, 2), "R10 promotion dropped");
    expect_lookup(8'h97, 1'b1, 1'b1, pay(8'h97, 2), "R10 later promote");

    // R2: ready low and requests ignored while a main read is pending
    write_line(8'hA8, pay(8'hA8, 3));
    @(negedge clk);
    lk_req = 1'b1; lk_addr = 8'hA8;
    @(negedge clk);
    lk_addr = 8'h83;
    check(!lk_ready && !lk_valid, "R2 busy", {30'd0, lk_ready, lk_valid}, 32'h0);
    @(negedge clk);
    lk_req = 1'b0;
    check(!lk_valid, "R2 ignored request", {31'd0, lk_valid}, 32'h0);
    @(negedge clk);
    check(lk_valid && lk_hit && !lk_fast && lk_data == pay(8'hA8, 3), "R2 latency",
          {13'd0, lk_valid, lk_hit, lk_fast, lk_data}, {16'h6, pay(8'hA8, 3)});
    @(negedge clk);
    check(!lk_valid && lk_ready, "R2 single response", {30'd0, lk_ready, lk_valid}, 32'h2);

    // R3: tag mismatch in an occupied set misses
    expect_lookup(8'hB8, 1'b0, 1'b0, '0, "R3 tag mismatch");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule